// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block drives a single open-drain data line as bus master. Time is measured with a one-cycle pulse that arrives once per microsecond. Every low period is a whole number of such ticks, and the block aligns the start of each low period to a tick. Each command starts one of these sequences:

- a reset sequence that reports whether any slave answered;
- a single write or read time slot;
- eight slots that move a whole byte, least significant bit first.

The host issues a command with a single-cycle valid strobe while the block is not busy. When the last slot and its recovery period are over, the block pulses `done` for one cycle. The received bit or byte is on `rx_data`, and the presence result is on `presence`. The block never drives the line high. It only raises `bus_pull`, which enables an external pull-down, and it reads the line back through `bus_in`.

Top module: `ow_master`

## Requirements
- R1: After reset, `bus_pull`, `busy`, `done` and `presence` are 0, and `rx_data` is 0.
- R2: Command code 0 (bus reset) holds `bus_pull` high for exactly 480 µs. It then keeps the line released until 960 µs after the falling edge, so the next low period starts at least 482 µs after the release.
- R3: After a bus reset, `presence` is 1 if the line is low 70 µs after the release, and 0 if it is high.
- R4: Command code 1 with `cmd_data[0]`=1 (write one) drives the line low for exactly 6 µs. It then leaves the line released for the rest of a 60 µs slot plus recovery, at least 56 µs in total.
- R5: Command code 1 with `cmd_data[0]`=0 (write zero) drives the line low for exactly 60 µs.
- R6: Command code 2 (read bit) drives the line low for exactly 6 µs and samples the line 13 µs after the falling edge. It returns the level as `rx_data[0]` (high reads 1, low reads 0), and `rx_data[7:1]` becomes 0.
- R7: Between the end of one slot's low period and the start of the next low period, the line stays released for at least 2 µs.
- R8: Command code 3 (write byte) issues eight write slots carrying `cmd_data` least significant bit first.
- R9: Command code 4 (read byte) issues eight read slots. The first sampled bit goes to `rx_data[0]` and the last to `rx_data[7]`.
- R10: `busy` is 1 from the cycle after a command is accepted until the cycle `done` is 1. A command presented while `busy` is 1 is ignored and starts no slot.
- R11: `done` is a single-cycle pulse at completion, and it falls in the first cycle in which `busy` is 0 again.
- R12: Command codes 5 to 7 are ignored: no slot, no `busy`, no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cmd_valid | input | 1 | Command strobe, taken when busy is 0 |
| cmd_op | input | 3 | Command code: 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| cmd_data | input | 8 | Write payload (bit 0 for a single write) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Presence result of the last bus reset |
| rx_data | output | 8 | Last received bit or byte |
| bus_pull | output | 1 | Enable for the external pull-down |
| bus_in | input | 1 | Sampled line level |

## Verification
A responding slave model pulls the line after the master's falling edges. It answers a reset with a presence pulse or stays silent, and in a read slot it holds the line low for a zero. Directed cases separate the four slot shapes by their measured low widths and check the released gaps after the long and short shapes. Byte writes and reads with asymmetric patterns such as 0xA5 and 0x3C show up any reversal of bit order. Random bytes and single bits with random slave replies then check that decoding and sampling do not depend on the data. Commands sent while busy, and unused codes, are shown to change neither the slot count nor the outputs.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } ow_op_e;

    typedef enum logic [1:0] {
        SLOT_RST,
        SLOT_W0,
        SLOT_W1,
        SLOT_RD
    } ow_slot_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ARM,
        ENG_ACTIVE,
        ENG_RECOVER
    } ow_eng_e;

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
    import ow_pkg::*;
#(
    parameter int RST_LOW_US   = 480,
    parameter int RST_TOTAL_US = 960,
    parameter int PRES_AT_US   = 70,
    parameter int SLOT_US      = 60,
    parameter int SHORT_LOW_US = 6,
    parameter int READ_AT_US   = 13,
    parameter int RECOVER_US   = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     start,
    input  ow_slot_e kind,
    input  logic     line,
    output logic     pull,
    output logic     done,
    output logic     bit_out
);
    localparam int CW = $clog2(RST_TOTAL_US + 1);
    localparam logic [CW-1:0] RST_LOW  = CW'(RST_LOW_US);
    localparam logic [CW-1:0] RST_END  = CW'(RST_TOTAL_US - 1);
    localparam logic [CW-1:0] RST_SMP  = CW'(RST_LOW_US + PRES_AT_US - 1);
    localparam logic [CW-1:0] SLT_END  = CW'(SLOT_US - 1);
    localparam logic [CW-1:0] SHT_LOW  = CW'(SHORT_LOW_US);
    localparam logic [CW-1:0] SLT_LOW  = CW'(SLOT_US);
    localparam logic [CW-1:0] RD_SMP   = CW'(READ_AT_US - 1);
    localparam logic [CW-1:0] REC_END  = CW'(RECOVER_US - 1);

    typedef struct packed {
        ow_eng_e       st;
        logic [CW-1:0] us;
        ow_slot_e      kind;
        logic          pull;
        logic          done;
        logic          smp;
    } eng_s;

    eng_s q, d;
    logic [CW-1:0] lim_low, lim_end, lim_smp;
    logic          smp_en;
    logic [CW-1:0] us_inc;

    always_comb begin
        lim_end = SLT_END;
        lim_smp = RD_SMP;
        smp_en  = 1'b0;
        lim_low = SHT_LOW;
        case (q.kind)
            SLOT_RST: begin lim_low = RST_LOW; lim_end = RST_END; lim_smp = RST_SMP; smp_en = 1'b1; end
            SLOT_W0:  lim_low = SLT_LOW;
            SLOT_W1:  lim_low = SHT_LOW;
            default:  smp_en  = 1'b1;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        us_inc = q.us + 1'b1;
        case (q.st)
            ENG_IDLE: begin
                if (start) begin
                    d.kind = kind;
                    d.st   = ENG_ARM;
                end
            end
            ENG_ARM: begin
                if (tick) begin
                    d.st   = ENG_ACTIVE;
                    d.us   = '0;
                    d.pull = 1'b1;
                end
            end
            ENG_ACTIVE: begin
                if (tick) begin
                    if (smp_en && q.us == lim_smp) d.smp = line;
                    if (q.us == lim_end) begin
                        d.st   = ENG_RECOVER;
                        d.us   = '0;
                        d.pull = 1'b0;
                    end else begin
                        d.us   = us_inc;
                        d.pull = (us_inc < lim_low);
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.us == REC_END) begin
                        d.st   = ENG_IDLE;
                        d.us   = '0;
                        d.done = 1'b1;
                    end else begin
                        d.us = us_inc;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ENG_IDLE, us: '0, kind: SLOT_RD, pull: 1'b0, done: 1'b0, smp: 1'b1};
        else        q <= d;
    end

    assign pull    = q.pull;
    assign done    = q.done;
    assign bit_out = q.smp;

    assert_released_in_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_RECOVER) |-> !q.pull);

    assert_low_starts_from_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pull) |-> ($past(q.st) == ENG_ARM));

    assert_start_only_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == ENG_IDLE));

    assert_done_leaves_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.st == ENG_IDLE && !q.pull));
endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int RST_LOW_US   = 480,
    parameter int RST_TOTAL_US = 960,
    parameter int PRES_AT_US   = 70,
    parameter int SLOT_US      = 60,
    parameter int SHORT_LOW_US = 6,
    parameter int READ_AT_US   = 13,
    parameter int RECOVER_US   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic              presence,
    output logic [BYTE_W-1:0] rx_data,
    output logic              bus_pull,
    input  logic              bus_in
);
    localparam int BCW = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic              run;
        logic              go;
        logic              single;
        ow_slot_e          kind;
        logic [BYTE_W-1:0] sh;
        logic [BCW-1:0]    left;
        logic              done;
        logic              pres;
        logic [BYTE_W-1:0] rx;
    } top_s;

    top_s q, d;
    logic line_s, eng_done, eng_bit;

    ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_in), .dout(line_s)
    );

    ow_slot_engine #(
        .RST_LOW_US(RST_LOW_US), .RST_TOTAL_US(RST_TOTAL_US), .PRES_AT_US(PRES_AT_US),
        .SLOT_US(SLOT_US), .SHORT_LOW_US(SHORT_LOW_US), .READ_AT_US(READ_AT_US),
        .RECOVER_US(RECOVER_US)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .start(q.go), .kind(q.kind),
        .line(line_s), .pull(bus_pull), .done(eng_done), .bit_out(eng_bit)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        if (!q.run && cmd_valid) begin
            case (cmd_op)
                OP_RESET: begin d.run = 1'b1; d.go = 1'b1; d.kind = SLOT_RST; d.left = BCW'(1); d.single = 1'b1; end
                OP_WBIT:  begin d.run = 1'b1; d.go = 1'b1; d.kind = cmd_data[0] ? SLOT_W1 : SLOT_W0;
                                d.sh = cmd_data; d.left = BCW'(1); d.single = 1'b1; end
                OP_RBIT:  begin d.run = 1'b1; d.go = 1'b1; d.kind = SLOT_RD; d.sh = '0;
                                d.left = BCW'(1); d.single = 1'b1; end
                OP_WBYTE: begin d.run = 1'b1; d.go = 1'b1; d.kind = cmd_data[0] ? SLOT_W1 : SLOT_W0;
                                d.sh = cmd_data; d.left = BCW'(BYTE_W); d.single = 1'b0; end
                OP_RBYTE: begin d.run = 1'b1; d.go = 1'b1; d.kind = SLOT_RD; d.sh = '0;
                                d.left = BCW'(BYTE_W); d.single = 1'b0; end
                default: ;
            endcase
        end else if (q.run && eng_done) begin
            d.left = q.left - 1'b1;
            if (q.kind == SLOT_RD) begin
                d.sh = {eng_bit, q.sh[BYTE_W-1:1]};
            end else begin
                d.sh   = q.sh >> 1;
                d.kind = d.sh[0] ? SLOT_W1 : SLOT_W0;
            end
            if (q.kind == SLOT_RST) d.pres = !eng_bit;
            if (q.left == BCW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
                if (q.kind == SLOT_RD)
                    d.rx = q.single ? {{(BYTE_W-1){1'b0}}, eng_bit} : d.sh;
            end else begin
                d.go = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{run: 1'b0, go: 1'b0, single: 1'b0, kind: SLOT_RD, sh: '0,
                           left: '0, done: 1'b0, pres: 1'b0, rx: '0};
        else        q <= d;
    end

    assign busy     = q.run;
    assign done     = q.done;
    assign presence = q.pres;
    assign rx_data  = q.rx;

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_bit_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.left <= BCW'(BYTE_W));

    assert_slot_end_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> busy);

    assert_no_pull_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !bus_pull);
endmodule

// File: tb/sim_ow_master.sv
`timescale 1ns/1ps
module sim_ow_master;
    localparam int TP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       busy, done, presence, bus_pull, bus_line;
    logic [7:0] rx_data;

    logic       slave_low;
    int         slv_mode = 0;
    logic       slv_present = 1'b0;
    logic [7:0] slv_bits = 8'd0;
    int         slv_base = 0;
    logic       slv_b;

    int nchk = 0, nfail = 0, cyc = 0;
    int tdiv = 0;
    int widths [0:1023];
    int gaps   [0:1023];
    int nlow = 0, wcnt = 0, gcnt = 100000;
    logic pull_prev = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tdiv <= (tdiv + 1) % TP;
    end
    assign us_tick = (tdiv == TP - 1);

    assign bus_line = !(bus_pull || slave_low);

    ow_master u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy), .done(done),
        .presence(presence), .rx_data(rx_data), .bus_pull(bus_pull), .bus_in(bus_line)
    );

    always @(posedge clk) begin
        pull_prev <= bus_pull;
        if (bus_pull) wcnt <= wcnt + 1;
        else          gcnt <= gcnt + 1;
        if (bus_pull && !pull_prev) begin
            gaps[nlow & 1023] <= gcnt;
            gcnt <= 0;
        end
        if (!bus_pull && pull_prev) begin
            widths[nlow & 1023] <= wcnt;
            nlow <= nlow + 1;
            wcnt <= 0;
        end
    end

    initial begin
        slave_low = 1'b0;
        forever begin
            @(posedge bus_pull);
            if (slv_mode == 2) begin
                slv_b = slv_bits[(nlow - slv_base) & 7];
                if (!slv_b) begin
                    slave_low = 1'b1;
                    repeat (30 * TP) @(posedge clk);
                    slave_low = 1'b0;
                end
            end else if (slv_mode == 1 && slv_present) begin
                @(negedge bus_pull);
                repeat (20 * TP) @(posedge clk);
                slave_low = 1'b1;
                repeat (100 * TP) @(posedge clk);
                slave_low = 1'b0;
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input int act, input int lim, input string tag);
        nchk++;
        if (act < lim) begin
            nfail++;
            $display("FAIL %s: actual %0d expected >= %0d", tag, act, lim);
        end
    endtask

    function automatic logic [7:0] decode_byte(input int base);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = (widths[(base + i) & 1023] < 15 * TP);
        return v;
    endfunction

    function automatic int min_gap(input int base, input int n);
        int m = 1000000;
        for (int i = 1; i < n; i++)
            if (gaps[(base + i) & 1023] < m) m = gaps[(base + i) & 1023];
        return m;
    endfunction

    task automatic pulse_cmd(input logic [2:0] op, input logic [7:0] dat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] dat);
        @(negedge clk);
        while (busy) @(negedge clk);
        pulse_cmd(op, dat);
        chk(busy, 1, "R10 busy after accept");
        while (!done) @(negedge clk);
        chk(busy, 0, "R11 busy low with done");
        @(negedge clk);
        chk(done, 0, "R11 done single cycle");
    endtask

    int base, seed;
    logic [7:0] rd, rv;
    logic [2:0] rop;

    initial begin
        repeat (5) @(negedge clk);
        chk(bus_pull, 0, "R1 pull at reset");
        chk(busy, 0, "R1 busy at reset");
        chk(done, 0, "R1 done at reset");
        chk(presence, 0, "R1 presence at reset");
        chk(rx_data, 0, "R1 rx at reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        seed = $urandom(32'd1234);

        // R2 / R3 reset with slave present
        slv_mode = 1; slv_present = 1'b1; base = nlow;
        do_cmd(3'd0, 8'd0);
        chk(widths[base & 1023], 480 * TP, "R2 reset low width");
        chk(presence, 1, "R3 presence detected");
        slv_mode = 0;
        do_cmd(3'd1, 8'd1);
        chk_ge(gaps[(base + 1) & 1023], 482 * TP, "R2 release after reset");

        // R3 no slave
        slv_mode = 1; slv_present = 1'b0;
        do_cmd(3'd0, 8'd0);
        chk(presence, 0, "R3 no presence");
        slv_mode = 0;

        // R4 / R5 / R7 single writes
        base = nlow;
        do_cmd(3'd1, 8'd1);
        do_cmd(3'd1, 8'd0);
        do_cmd(3'd1, 8'd0);
        chk(widths[base & 1023], 6 * TP, "R4 write-one low width");
        chk_ge(gaps[(base + 1) & 1023], 56 * TP, "R4 release after write-one");
        chk(widths[(base + 1) & 1023], 60 * TP, "R5 write-zero low width");
        chk_ge(gaps[(base + 2) & 1023], 2 * TP, "R7 recovery after write-zero");

        // R6 read bits
        slv_mode = 2; slv_bits = 8'hFF; base = nlow; slv_base = nlow;
        do_cmd(3'd2, 8'd0);
        chk(rx_data, 1, "R6 read one");
        chk(widths[base & 1023], 6 * TP, "R6 read low width");
        slv_bits = 8'h00; slv_base = nlow;
        do_cmd(3'd2, 8'd0);
        chk(rx_data, 0, "R6 read zero");

        // R8 write byte
        slv_mode = 0; base = nlow;
        do_cmd(3'd3, 8'hA5);
        chk(nlow - base, 8, "R8 slot count");
        chk(decode_byte(base), 8'hA5, "R8 byte order");
        chk_ge(min_gap(base, 8), 2 * TP, "R7 min gap in byte");

        // R9 read byte
        slv_mode = 2; slv_bits = 8'h3C; slv_base = nlow;
        do_cmd(3'd4, 8'd0);
        chk(rx_data, 8'h3C, "R9 read byte");

        // R10 command while busy ignored
        slv_mode = 0; base = nlow;
        @(negedge clk);
        pulse_cmd(3'd3, 8'h0F);
        repeat (50) @(negedge clk);
        pulse_cmd(3'd2, 8'd0);
        while (!done) @(negedge clk);
        repeat (400) @(negedge clk);
        chk(nlow - base, 8, "R10 ignored while busy slot count");
        chk(busy, 0, "R10 idle after ignored command");
        chk(rx_data, 8'h3C, "R10 rx unchanged");

        // R12 unused codes
        base = nlow;
        for (int c = 5; c < 8; c++) begin
            pulse_cmd(3'(c), 8'hFF);
            repeat (3) @(negedge clk);
            chk(busy, 0, "R12 unused code busy");
            chk(done, 0, "R12 unused code done");
        end
        repeat (400) @(negedge clk);
        chk(nlow - base, 0, "R12 unused code slots");

        // random mix
        for (int it = 0; it < 14; it++) begin
            rop = 3'(1 + ($urandom % 4));
            rd  = 8'($urandom);
            rv  = 8'($urandom);
            slv_mode = (rop == 3'd2 || rop == 3'd4) ? 2 : 0;
            slv_bits = rv; base = nlow; slv_base = nlow;
            do_cmd(rop, rd);
            case (rop)
                3'd1: chk(widths[base & 1023], rd[0] ? 6 * TP : 60 * TP, "R4 R5 random bit");
                3'd2: chk(rx_data, {7'd0, rv[0]}, "R6 random read bit");
                3'd3: chk(decode_byte(base), rd, "R8 random byte");
                default: chk(rx_data, rv, "R9 random read byte");
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule